// File: doc/BRIEF.md
# Indexed Two-Bit Branch Direction Table

This block guesses whether a conditional branch will be taken. It keeps a table of small two-bit state entries. A few low-order bits of the branch address choose the entry, and there is no tag. During fetch, the lookup side takes a program counter and returns a taken or not-taken guess in the same cycle, through logic with no register in the path. Later, when the branch resolves, the update side takes that branch's address and its real outcome. It then moves the selected entry to a new state according to one of three rules.

The rule input is meant to stay fixed while the table runs. There are three rules:
- A one-bit rule, which simply remembers the last outcome.
- A saturating counter, which moves one step per outcome.
- A hysteresis rule. A miss in a weak state jumps straight to the strong state of the opposite direction.

A synchronous reset puts every entry back into the weak-taken state.

Top module: `branch_dir_table`

## Requirements
- R1: While `rst` is high at a clock edge, every entry is loaded with weak-taken (encoding 2'b10). After that edge, every lookup predicts taken until an update changes the entry.
- R2: The entry index is `pc[PC_LSB+IDX_BITS-1:PC_LSB]`, and no tag is stored. With the defaults this is bits [7:2], giving 64 entries. Addresses with the same index bits share one entry, whatever their other bits are.
- R3: `predTaken` is the upper bit of the entry selected by `lookupPc`. It is valid in the same cycle, and the entry encodings are 00 strong-not-taken, 01 weak-not-taken, 10 weak-taken and 11 strong-taken.
- R4: With `ruleSel`=0 (one-bit), an update writes 11 for taken and 00 for not-taken. The next prediction for that entry therefore equals the last recorded outcome.
- R5: With `ruleSel`=1, and also with the unused code 3 (saturating), taken adds one and not-taken subtracts one. The count holds at 11 and at 00.
- R6: With `ruleSel`=2 (hysteresis), the transitions are as follows. Taken moves 00 to 01, 01 to 11, 10 to 11 and 11 to 11. Not-taken moves 11 to 10, and moves 10, 01 and 00 to 00.
- R7: In both two-bit rules, an entry in a strong state keeps its predicted direction after one miss. A correctly predicted outcome never changes the predicted direction, in any rule.
- R8: Start from weak-taken and apply the alternating outcomes NT,T,NT,T,NT,T, each looked up just before its update. The saturating rule mispredicts all six. The hysteresis rule mispredicts the first two, and after that only the taken ones.
- R9: When a lookup and an update hit the same index in one cycle, the lookup returns the state from before the update. The new state is seen from the next cycle on.
- R10: When `updValid` is low, no entry changes, whatever `updPc` and `updTaken` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; loads weak-taken into all entries |
| ruleSel | input | 2 | Static update rule: 0 one-bit, 1 saturating, 2 hysteresis, 3 saturating |
| lookupPc | input | PC_WIDTH | Fetch address to predict |
| predTaken | output | 1 | Prediction for `lookupPc`, 1 = taken |
| updValid | input | 1 | Resolved branch update strobe |
| updPc | input | PC_WIDTH | Address of the resolved branch |
| updTaken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The one case where the two sides of the block collide is a lookup and an update aimed at the same entry in the same cycle. The bench provokes it deliberately. The alternating outcome streams are driven with the lookup and the update of each branch placed in one cycle. A dedicated step also sends a not-taken update to an entry that is still weak-taken while looking that entry up. Each such lookup is judged against a reference table in the bench that is updated only after the expected value has been queued. A correct result therefore shows the state from before the write, and the following cycle's lookup must show the state after it.

// File: rtl/bdt_pkg.sv
package bdt_pkg;

  typedef enum logic [1:0] {
    RULE_ONEBIT  = 2'd0,
    RULE_SAT     = 2'd1,
    RULE_HYST    = 2'd2,
    RULE_SAT_ALT = 2'd3
  } rule_e;

  localparam logic [1:0] ST_SNT = 2'b00;
  localparam logic [1:0] ST_WNT = 2'b01;
  localparam logic [1:0] ST_WT  = 2'b10;
  localparam logic [1:0] ST_ST  = 2'b11;

  typedef struct packed {
    logic       clrAll;
    logic       wrEn;
    logic [1:0] wrState;
  } bdt_strobe_t;

endpackage

// File: rtl/bdt_ctrl.sv
module bdt_ctrl
  import bdt_pkg::*;
(
  input  logic        rst,
  input  logic [1:0]  ruleSel,
  input  logic        updValid,
  input  logic        updTaken,
  input  logic [1:0]  updCur,
  output bdt_strobe_t stb
);

  rule_e rule;
  logic [1:0] nextState;

  assign rule = rule_e'(ruleSel);

  always_comb begin
    unique case (rule)
      RULE_ONEBIT: nextState = updTaken ? ST_ST : ST_SNT;
      RULE_HYST: begin
        if (updTaken)
          nextState = (updCur == ST_SNT) ? ST_WNT : ST_ST;
        else
          nextState = (updCur == ST_ST) ? ST_WT : ST_SNT;
      end
      default: begin
        if (updTaken)
          nextState = (updCur == ST_ST) ? ST_ST : updCur + 2'd1;
        else
          nextState = (updCur == ST_SNT) ? ST_SNT : updCur - 2'd1;
      end
    endcase
  end

  always_comb begin
    stb.clrAll  = rst;
    stb.wrEn    = updValid && !rst;
    stb.wrState = nextState;
  end

endmodule

// File: rtl/bdt_table.sv
module bdt_table
  import bdt_pkg::*;
#(
  parameter int IDX_BITS = 6,
  parameter int PC_WIDTH = 32,
  parameter int PC_LSB   = 2
) (
  input  logic                clk,
  input  bdt_strobe_t         stb,
  input  logic [PC_WIDTH-1:0] lookupPc,
  input  logic [PC_WIDTH-1:0] updPc,
  output logic                predTaken,
  output logic [1:0]          updCur
);

  localparam int ENTRIES = 1 << IDX_BITS;

  logic [1:0] tbl [ENTRIES];
  logic [IDX_BITS-1:0] lkIdx;
  logic [IDX_BITS-1:0] upIdx;

  assign lkIdx = lookupPc[PC_LSB +: IDX_BITS];
  assign upIdx = updPc[PC_LSB +: IDX_BITS];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (stb.clrAll)
        tbl[e] <= ST_WT;
      else if (stb.wrEn && upIdx == IDX_BITS'(e))
        tbl[e] <= stb.wrState;
    end
  end

  assign predTaken = tbl[lkIdx][1];
  assign updCur    = tbl[upIdx];

endmodule

// File: rtl/branch_dir_table.sv
module branch_dir_table
  import bdt_pkg::*;
#(
  parameter int IDX_BITS = 6,
  parameter int PC_WIDTH = 32,
  parameter int PC_LSB   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          ruleSel,
  input  logic [PC_WIDTH-1:0] lookupPc,
  output logic                predTaken,
  input  logic                updValid,
  input  logic [PC_WIDTH-1:0] updPc,
  input  logic                updTaken
);

  bdt_strobe_t stb;
  logic [1:0]  updCur;

  bdt_ctrl ctrl_i (
    .rst      (rst),
    .ruleSel  (ruleSel),
    .updValid (updValid),
    .updTaken (updTaken),
    .updCur   (updCur),
    .stb      (stb)
  );

  bdt_table #(
    .IDX_BITS (IDX_BITS),
    .PC_WIDTH (PC_WIDTH),
    .PC_LSB   (PC_LSB)
  ) table_i (
    .clk       (clk),
    .stb       (stb),
    .lookupPc  (lookupPc),
    .updPc     (updPc),
    .predTaken (predTaken),
    .updCur    (updCur)
  );

endmodule

// File: rtl/bdt_checker.sv
module bdt_checker #(
  parameter int IDX_BITS = 6,
  parameter int PC_WIDTH = 32,
  parameter int PC_LSB   = 2
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          ruleSel,
  input logic [PC_WIDTH-1:0] lookupPc,
  input logic                predTaken,
  input logic                updValid,
  input logic [PC_WIDTH-1:0] updPc,
  input logic                updTaken,
  input logic [1:0]          updCur
);

  logic [IDX_BITS-1:0] lkIdx;
  logic [IDX_BITS-1:0] upIdx;
  assign lkIdx = lookupPc[PC_LSB +: IDX_BITS];
  assign upIdx = updPc[PC_LSB +: IDX_BITS];

  AST_RESET_LOADS_WT: assert property (@(posedge clk)
    rst |=> predTaken); // R1

  AST_ONEBIT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (updValid && ruleSel == 2'd0) |=>
      (lkIdx != $past(upIdx)) || (predTaken == $past(updTaken))); // R4

  AST_HIT_KEEPS_DIR: assert property (@(posedge clk) disable iff (rst)
    (updValid && updCur[1] == updTaken) |=>
      (lkIdx != $past(upIdx)) || (predTaken == $past(updTaken))); // R7

  AST_STRONG_T_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (updValid && ruleSel != 2'd0 && updCur == 2'b11 && !updTaken) |=>
      (lkIdx != $past(upIdx)) || predTaken); // R7

  AST_HYST_WT_DROPS: assert property (@(posedge clk) disable iff (rst)
    (updValid && ruleSel == 2'd2 && updCur == 2'b10 && !updTaken) |=>
      (upIdx != $past(upIdx)) || (updCur == 2'b00)); // R6

  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (!updValid) |=> (upIdx != $past(upIdx)) || $stable(updCur)); // R10

endmodule

bind branch_dir_table bdt_checker #(
  .IDX_BITS (IDX_BITS),
  .PC_WIDTH (PC_WIDTH),
  .PC_LSB   (PC_LSB)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .ruleSel   (ruleSel),
  .lookupPc  (lookupPc),
  .predTaken (predTaken),
  .updValid  (updValid),
  .updPc     (updPc),
  .updTaken  (updTaken),
  .updCur    (updCur)
);

// File: tb/branch_dir_table_tb_top.sv
`timescale 1ns/1ps
module branch_dir_table_tb_top;

  localparam int IDX_BITS = 6;
  localparam int PC_WIDTH = 32;
  localparam int PC_LSB   = 2;
  localparam int ENTRIES  = 1 << IDX_BITS;

  typedef struct {
    bit    exp;
    string tag;
  } sb_item_t;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [1:0]          ruleSel = 2'd1;
  logic [PC_WIDTH-1:0] lookupPc = '0;
  logic                predTaken;
  logic                updValid = 1'b0;
  logic [PC_WIDTH-1:0] updPc = '0;
  logic                updTaken = 1'b0;

  int  checks = 0;
  int  failures = 0;
  bit  lkFlag = 1'b0;
  bit  finished = 1'b0;
  logic [1:0] mdl [ENTRIES];
  sb_item_t sbq [$];

  always #4 clk = ~clk;

  branch_dir_table #(
    .IDX_BITS (IDX_BITS),
    .PC_WIDTH (PC_WIDTH),
    .PC_LSB   (PC_LSB)
  ) dut_i (
    .clk       (clk),
    .rst       (rst),
    .ruleSel   (ruleSel),
    .lookupPc  (lookupPc),
    .predTaken (predTaken),
    .updValid  (updValid),
    .updPc     (updPc),
    .updTaken  (updTaken)
  );

  function automatic logic [PC_WIDTH-1:0] mkPc(input int idx, input int hi, input int lo);
    return (PC_WIDTH'(hi) << (PC_LSB + IDX_BITS)) | (PC_WIDTH'(idx) << PC_LSB) | PC_WIDTH'(lo);
  endfunction

  function automatic logic [1:0] refNext(input logic [1:0] r, input logic [1:0] s, input bit t);
    logic [1:0] n;
    if (r == 2'd0) n = t ? 2'b11 : 2'b00;
    else if (r == 2'd2) begin
      case ({s, t})
        3'b000: n = 2'b00; 3'b001: n = 2'b01;
        3'b010: n = 2'b00; 3'b011: n = 2'b11;
        3'b100: n = 2'b00; 3'b101: n = 2'b11;
        3'b110: n = 2'b10; default: n = 2'b11;
      endcase
    end else begin
      case ({s, t})
        3'b000: n = 2'b00; 3'b001: n = 2'b01;
        3'b010: n = 2'b00; 3'b011: n = 2'b10;
        3'b100: n = 2'b01; 3'b101: n = 2'b11;
        3'b110: n = 2'b10; default: n = 2'b11;
      endcase
    end
    return n;
  endfunction

  task automatic mdlReset();
    for (int i = 0; i < ENTRIES; i++) mdl[i] = 2'b10;
  endtask

  // Driver: one cycle of optional lookup and optional update
  task automatic step(input bit lk, input logic [PC_WIDTH-1:0] lpc,
                      input bit uv, input logic [PC_WIDTH-1:0] upc,
                      input bit ut, input string tag);
    sb_item_t it;
    lookupPc = lpc;
    updValid = uv;
    updPc    = upc;
    updTaken = ut;
    lkFlag   = lk;
    if (lk) begin
      it.exp = mdl[lpc[PC_LSB +: IDX_BITS]][1];
      it.tag = tag;
      sbq.push_back(it);
    end
    @(posedge clk);
    if (uv) mdl[upc[PC_LSB +: IDX_BITS]] = refNext(ruleSel, mdl[upc[PC_LSB +: IDX_BITS]], ut);
    #1;
    lkFlag   = 1'b0;
    updValid = 1'b0;
  endtask

  task automatic look(input int idx, input string tag);
    step(1'b1, mkPc(idx, 0, 0), 1'b0, '0, 1'b0, tag);
  endtask

  task automatic upd(input int idx, input bit t);
    step(1'b0, '0, 1'b1, mkPc(idx, 0, 0), t, "");
  endtask

  // Monitor: pops expected items and compares
  always @(negedge clk) begin
    if (lkFlag && sbq.size() > 0) begin
      sb_item_t it;
      it = sbq.pop_front();
      checks++;
      if (predTaken !== it.exp) begin
        failures++;
        $display("FAIL %s: predTaken actual=%0b expected=%0b at %0t", it.tag, predTaken, it.exp, $time);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    mdlReset();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state, R3 same-cycle prediction
    look(0, "R1"); look(5, "R1"); look(63, "R3");

    // R5 saturating steps, R7 one miss from strong keeps direction
    ruleSel = 2'd1;
    upd(3, 1); look(3, "R5");
    upd(3, 0); look(3, "R7");
    upd(3, 0); look(3, "R5");
    upd(3, 0); upd(3, 0); look(3, "R5");
    upd(3, 1); look(3, "R5");
    upd(3, 1); look(3, "R5");

    // R8 saturating alternating stream, lookup with update (R9)
    for (int i = 0; i < 6; i++) step(1'b1, mkPc(10, 0, 0), 1'b1, mkPc(10, 0, 0), bit'(i % 2), "R8");

    // R6 hysteresis, R8 alternating stream
    ruleSel = 2'd2;
    for (int i = 0; i < 6; i++) step(1'b1, mkPc(20, 0, 0), 1'b1, mkPc(20, 0, 0), bit'(i % 2), "R8");
    upd(21, 1); upd(21, 0); look(21, "R7");
    upd(21, 0); look(21, "R6");
    upd(21, 1); look(21, "R6");
    upd(21, 1); look(21, "R6");

    // R4 one-bit rule
    ruleSel = 2'd0;
    upd(30, 0); look(30, "R4");
    upd(30, 1); look(30, "R4");
    upd(30, 0); look(30, "R4");

    // R2 aliasing: upper and low alignment bits ignored
    ruleSel = 2'd1;
    upd(40, 0); upd(40, 0);
    step(1'b1, mkPc(40, 5, 3), 1'b0, '0, 1'b0, "R2");
    look(41, "R2");

    // R9 collision: pre-update state seen, new state next cycle
    step(1'b1, mkPc(50, 0, 0), 1'b1, mkPc(50, 0, 0), 1'b0, "R9");
    look(50, "R9");

    // R10 updValid low has no effect
    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b0, mkPc(60, 0, 0), 1'b0, "");
    look(60, "R10");

    // R5 code 3 behaves saturating
    ruleSel = 2'd3;
    upd(45, 0); look(45, "R5");
    upd(45, 0); upd(45, 1); look(45, "R5");

    // R1 reset reloads trained entries
    rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    mdlReset();
    look(3, "R1"); look(30, "R1"); look(45, "R1");

    repeat (2) @(posedge clk);
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule